// File: doc/BRIEF.md
# Video Timing Event Interrupt Controller

This block watches the vertical sync and data-enable strobes of a video stream, plus an external tearing-effect pulse, and turns chosen timing events into one level interrupt. Its inputs have already been put into active-high form upstream. It finds rising and falling edges by comparing each input with its value one clock earlier. It also detects the end of a frame: the moment vertical sync rises after at least one complete data-enable pulse has occurred since the previous vertical sync rise.

Software sees one 32-bit word. The low half holds one enable per event. The high half holds one sticky flag per event in the same order, shifted up by 16. A flag is cleared by writing 1 to it. The interrupt line is high while any flag is set. The host port is a plain write strobe with write data, and a read value that always shows the current word.

Top module: `vtim_irq_ctrl`

## Requirements
- R1: After reset the read value is 0x00000000 and the interrupt is low.
- R2: Bits [5:0] are read/write enables. Bits [15:6] and [31:22] always read 0 and ignore writes.
- R3: Each event sets its status flag only while its enable is 1, with this mapping: te_in rising edge sets bit 16 (enable bit 0); vsync rising sets bit 17 (bit 1); vsync falling sets bit 18 (bit 2); de rising sets bit 19 (bit 3); de falling sets bit 20 (bit 4); end of frame sets bit 21 (bit 5). The flag becomes visible one clock after the edge is presented.
- R4: Writing 1 to a bit in [21:16] clears that flag. Writing 0 leaves it unchanged.
- R5: When an event and a clear of the same flag occur in the same cycle, the flag ends up set.
- R6: Each edge raises its event for exactly one cycle. A level that stays high does not set the flag again after the flag has been cleared.
- R7: End of frame is raised on a vsync rising edge only if a de falling edge has occurred since the previous vsync rise, counting a de fall in that same cycle. A vsync rise with no such de pulse raises only the vsync-rise event.
- R8: The interrupt output is registered and always equals the OR of status bits [21:16].
- R9: An enable write takes effect at the clock edge that stores it. An event in the same cycle as that write is judged against the old enable value.
- R10: Flags stay set until they are cleared, whatever the inputs do afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| vsync_in | input | 1 | Vertical sync, active high |
| de_in | input | 1 | Data enable, active high |
| te_in | input | 1 | External tearing-effect event |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Register write data |
| rd_data | output | 32 | Current register value |
| irq | output | 1 | Level interrupt |

## Verification
The bound checker checks the following on every cycle: the interrupt matches the OR of the flags; reserved bits stay zero; no flag rises without its event and enable from the cycle before; a clear with no competing event drops the flag; a simultaneous event wins over a clear; and end of frame only appears together with a vsync rise. The mapping from each input waveform to the right flag, and the frame-level ordering of de pulses against vsync, can only be shown by the bench's scenarios. This is also true of the held-level case and of enable writes that coincide with events. The bench sweeps all 64 enable masks through a full event sequence.

// File: rtl/vtim_irq_pkg.sv
package vtim_irq_pkg;

  // number of timing events handled by the block
  localparam int EVT_N = 6;

  // event positions inside the enable / status fields
  localparam int EV_TE  = 0;
  localparam int EV_VSR = 1;
  localparam int EV_VSF = 2;
  localparam int EV_DER = 3;
  localparam int EV_DEF = 4;
  localparam int EV_EOF = 5;

  // raw inputs fed to the edge finder
  localparam int SIG_TE = 0;
  localparam int SIG_VS = 1;
  localparam int SIG_DE = 2;
  localparam int SIG_N  = 3;

  typedef logic [EVT_N-1:0] evt_vec_t;

  // sticky flag update: set has priority over clear
  function automatic evt_vec_t flag_next(evt_vec_t cur, evt_vec_t hit,
                                         evt_vec_t en, evt_vec_t clr);
    return (cur & ~clr) | (hit & en);
  endfunction

  // end of frame: vsync rise after a completed de pulse
  function automatic logic frame_end(logic vs_rise, logic seen_de, logic de_fall);
    return vs_rise & (seen_de | de_fall);
  endfunction

  // pack enables and flags into the software word
  function automatic logic [31:0] pack_word(evt_vec_t en, evt_vec_t st, int half);
    logic [31:0] w;
    w = '0;
    for (int i = 0; i < EVT_N; i++) begin
      w[i]        = en[i];
      w[half + i] = st[i];
    end
    return w;
  endfunction

endpackage

// File: rtl/vtim_edge_find.sv
module vtim_edge_find #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] sig_in,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);

  logic [W-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= sig_in;
  end

  for (genvar g = 0; g < W; g++) begin : g_edge
    assign rise[g] =  sig_in[g] & ~prev_q[g];
    assign fall[g] = ~sig_in[g] &  prev_q[g];
  end

endmodule

// File: rtl/vtim_frame_end.sv
module vtim_frame_end
  import vtim_irq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic vs_rise,
  input  logic de_fall,
  output logic eof_pulse
);

  logic seen_de_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       seen_de_q <= 1'b0;
    else if (vs_rise) seen_de_q <= 1'b0;
    else if (de_fall) seen_de_q <= 1'b1;
  end

  assign eof_pulse = frame_end(vs_rise, seen_de_q, de_fall);

endmodule

// File: rtl/vtim_irq_regs.sv
module vtim_irq_regs
  import vtim_irq_pkg::*;
#(
  parameter int REG_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  evt_vec_t         en_wdata,
  input  evt_vec_t         clr_req,
  input  evt_vec_t         hit,
  output evt_vec_t         en_q,
  output evt_vec_t         stat_q,
  output logic             irq_q
);

  evt_vec_t stat_d;

  assign stat_d = flag_next(stat_q, hit, en_q, clr_req);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      stat_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      if (wr_en) en_q <= en_wdata;
      stat_q <= stat_d;
      irq_q  <= |stat_d;
    end
  end

endmodule

// File: rtl/vtim_irq_ctrl.sv
module vtim_irq_ctrl
  import vtim_irq_pkg::*;
#(
  parameter int REG_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             vsync_in,
  input  logic             de_in,
  input  logic             te_in,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  output logic             irq
);

  localparam int HALF_W = REG_W / 2;

  logic [SIG_N-1:0] raw_sig, sig_rise, sig_fall;
  evt_vec_t evt_hit;
  evt_vec_t clr_req;
  evt_vec_t en_wdata;
  evt_vec_t en_q, stat_q;
  logic     eof_pulse;
  logic     unused_bits;

  assign raw_sig[SIG_TE] = te_in;
  assign raw_sig[SIG_VS] = vsync_in;
  assign raw_sig[SIG_DE] = de_in;

  vtim_edge_find #(.W(SIG_N)) u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .sig_in (raw_sig),
    .rise   (sig_rise),
    .fall   (sig_fall)
  );

  vtim_frame_end u_eof (
    .clk       (clk),
    .rst_n     (rst_n),
    .vs_rise   (sig_rise[SIG_VS]),
    .de_fall   (sig_fall[SIG_DE]),
    .eof_pulse (eof_pulse)
  );

  assign evt_hit[EV_TE]  = sig_rise[SIG_TE];
  assign evt_hit[EV_VSR] = sig_rise[SIG_VS];
  assign evt_hit[EV_VSF] = sig_fall[SIG_VS];
  assign evt_hit[EV_DER] = sig_rise[SIG_DE];
  assign evt_hit[EV_DEF] = sig_fall[SIG_DE];
  assign evt_hit[EV_EOF] = eof_pulse;

  for (genvar g = 0; g < EVT_N; g++) begin : g_field
    assign en_wdata[g] = wr_data[g];
    assign clr_req[g]  = wr_en & wr_data[HALF_W + g];
  end

  assign unused_bits = ^{wr_data[REG_W-1:HALF_W+EVT_N], wr_data[HALF_W-1:EVT_N],
                         sig_fall[SIG_TE]};

  vtim_irq_regs #(.REG_W(REG_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .en_wdata (en_wdata),
    .clr_req  (clr_req),
    .hit      (evt_hit),
    .en_q     (en_q),
    .stat_q   (stat_q),
    .irq_q    (irq)
  );

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < EVT_N; i++) begin
      rd_data[i]          = en_q[i];
      rd_data[HALF_W + i] = stat_q[i];
    end
  end

endmodule

// File: rtl/vtim_irq_chk.sv
module vtim_irq_chk
  import vtim_irq_pkg::*;
#(
  parameter int REG_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic [REG_W-1:0] rd_data,
  input logic             irq,
  input evt_vec_t         hit,
  input evt_vec_t         clr_req
);

  localparam int HALF_W = REG_W / 2;

  // R8
  irq_matches_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq == |rd_data[HALF_W +: EVT_N]);

  // R2
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[REG_W-1:HALF_W+EVT_N] == '0) && (rd_data[HALF_W-1:EVT_N] == '0));

  // R7
  eof_with_vs_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit[EV_EOF] |-> hit[EV_VSR]);

  for (genvar g = 0; g < EVT_N; g++) begin : g_bit
    // R3
    flag_needs_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hit[g] && !rd_data[g] |=> $past(rd_data[HALF_W + g]) == rd_data[HALF_W + g]
                                 || !rd_data[HALF_W + g]);
    // R4
    clear_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr_req[g] && !hit[g] |=> !rd_data[HALF_W + g]);
    // R5
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hit[g] && rd_data[g] |=> rd_data[HALF_W + g]);
    // R10
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_data[HALF_W + g] && !clr_req[g] |=> rd_data[HALF_W + g]);
  end

endmodule

bind vtim_irq_ctrl vtim_irq_chk #(.REG_W(REG_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .rd_data (rd_data),
  .irq     (irq),
  .hit     (evt_hit),
  .clr_req (clr_req)
);

// File: tb/vtim_irq_ctrl_test.sv
module vtim_irq_ctrl_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        vsync_in = 1'b0;
  logic        de_in = 1'b0;
  logic        te_in = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        irq;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  vtim_irq_ctrl uut (
    .clk      (clk),
    .rst_n    (rst_n),
    .vsync_in (vsync_in),
    .de_in    (de_in),
    .te_in    (te_in),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .rd_data  (rd_data),
    .irq      (irq)
  );

  function automatic logic [31:0] word_of(logic [5:0] en, logic [5:0] st);
    return (32'(st) << 16) | 32'(en);
  endfunction

  task automatic check(input string req, input logic [5:0] en, input logic [5:0] st);
    logic [31:0] exp_rd;
    logic        exp_irq;
    exp_rd  = word_of(en, st);
    exp_irq = (st != 6'd0);
    n_run++;
    if (rd_data !== exp_rd || irq !== exp_irq) begin
      n_fail++;
      $display("FAIL %s: rd_data=%08h irq=%b expected rd_data=%08h irq=%b",
               req, rd_data, irq, exp_rd, exp_irq);
    end
  endtask

  // one clock with the given input levels, returns at the next falling edge
  task automatic step(input logic v, input logic d, input logic t);
    vsync_in = v; de_in = d; te_in = t;
    @(posedge clk); @(negedge clk);
  endtask

  task automatic wr(input logic [31:0] data);
    wr_en = 1'b1; wr_data = data;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic wr_step(input logic [31:0] data, input logic v, input logic d, input logic t);
    wr_en = 1'b1; wr_data = data;
    vsync_in = v; de_in = d; te_in = t;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", 6'h00, 6'h00);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", 6'h00, 6'h00);

    // R2 reserved bits ignore writes, enables read back
    wr(32'hFFFF_FFFF);
    check("R2", 6'h3F, 6'h00);
    wr(32'hFFC0_FFC0);
    check("R2", 6'h00, 6'h00);

    // R3 R7 R4 sweep across every enable mask
    for (int m = 0; m < 64; m++) begin
      logic [5:0] mk;
      mk = 6'(m);
      wr(32'h003F_0000 | 32'(mk));
      check("R4", mk, 6'h00);
      step(0, 0, 1); check("R3 te", mk, mk & 6'b000001);
      wr(32'h003F_0000 | 32'(mk)); check("R4", mk, 6'h00);
      step(0, 0, 0); check("R6 te fall", mk, 6'h00);
      step(1, 0, 0); check("R7 vs rise no de", mk, mk & 6'b000010);
      wr(32'h003F_0000 | 32'(mk));
      step(0, 0, 0); check("R3 vs fall", mk, mk & 6'b000100);
      wr(32'h003F_0000 | 32'(mk));
      step(0, 1, 0); check("R3 de rise", mk, mk & 6'b001000);
      wr(32'h003F_0000 | 32'(mk));
      step(0, 0, 0); check("R3 de fall", mk, mk & 6'b010000);
      wr(32'h003F_0000 | 32'(mk));
      step(1, 0, 0); check("R7 eof", mk, mk & 6'b100010);
      wr(32'h003F_0000 | 32'(mk));
      step(0, 0, 0); check("R3 vs fall", mk, mk & 6'b000100);
      wr(32'h003F_0000 | 32'(mk));
      check("R8 irq low after clear", mk, 6'h00);
    end

    // R4 writing 0 keeps flags, partial clear
    wr(32'h0000_003F);
    step(0, 1, 1);                // de rise + te rise
    check("R3", 6'h3F, 6'b001001);
    wr(32'h0000_003F);
    check("R4 zero write keeps", 6'h3F, 6'b001001);
    wr(32'h0001_003F);
    check("R4 partial clear", 6'h3F, 6'b001000);

    // R10 flags persist while inputs move
    step(0, 1, 0); step(0, 1, 0);
    check("R10", 6'h3F, 6'b001000);

    // R7 de fall in the same cycle as vs rise
    wr(32'h003F_003F);
    step(1, 0, 0);
    check("R7 same-cycle eof", 6'h3F, 6'b110010);

    // R6 held level does not retrigger
    wr(32'h003F_003F);
    step(1, 0, 0); step(1, 0, 0); step(1, 0, 0);
    check("R6 held vs", 6'h3F, 6'h00);
    step(0, 0, 0);
    wr(32'h003F_003F);

    // R5 set wins over clear
    wr_step(32'h003F_003F, 0, 0, 1);
    check("R5", 6'h3F, 6'b000001);
    wr_step(32'h003F_003F, 0, 0, 0);
    check("R5 then clear", 6'h3F, 6'h00);

    // R9 enabling in the same cycle as the event misses it
    wr(32'h003F_0000);
    wr_step(32'h0000_0002, 1, 0, 0);
    check("R9 late enable", 6'h02, 6'h00);
    // R9 disabling in the same cycle as the event still captures it
    wr(32'h0000_0004);
    wr_step(32'h0000_0000, 0, 0, 0);
    check("R9 late disable", 6'h00, 6'b000100);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule